// File: doc/BRIEF.md
# ATA Device Task-File Register Block

This block is the device side of a parallel ATA-style register file. A host reaches it over a simple register bus: an address, a one-cycle read strobe, a one-cycle write strobe and a 16-bit data path. The block decodes each access into the status, alternate-status, command, device-control, parameter and data registers. It keeps the interrupt-pending state and drives the host interrupt line. It hands each accepted command to a command engine as a code, a start pulse and a frozen copy of the parameter bytes.

The command engine drives the busy and transfer phases through a few pulses. One pulse opens a PIO data phase with a length, a direction and a byte-wide ECC option. Another releases the busy state. A third posts an interrupt. During a data phase each host access to the data register moves one word through a first-word-fall-through buffer port. The phase closes by itself after the programmed number of accesses. Accesses outside an open phase never touch the buffer.

Top module: `ata_taskfile_regs`

## Requirements
- R1: A read of the status register (address 7) returns a byte with BSY at bit 7, DRQ at bit 3, and engine flags 5..3 at bits 6..4 and 2..0 at bits 2..0. After reset BSY and DRQ are both 0.
- R2: A read of the alternate status register (address 14) returns the same byte as a status read, and it leaves the interrupt-pending state unchanged.
- R3: A status read clears interrupt-pending. An engine interrupt request sets it. When both happen in the same cycle, the request wins.
- R4: The interrupt output equals pending AND NOT disable, updated one cycle after the cause. The disable bit is bit 1 of a write to the device-control register (address 14).
- R5: A command write (address 7) while BSY is 0 does four things. It raises the start output for exactly the next cycle, presents write bits 7..0 as the command code, sets BSY and clears DRQ.
- R6: A command write while BSY is 1 is ignored: no start pulse, and the code stays unchanged.
- R7: Parameter registers at addresses 1..6 store write bits 7..0 and read back zero-extended. The engine parameter bus is a copy taken at each accepted command, with the byte for address k at bits 8k-1..8k-8. Later writes do not change it.
- R8: A transfer-open pulse sets DRQ, clears BSY, restarts the word count and latches length, direction and ECC mode. BSY and DRQ are never 1 together.
- R9: In a device-to-host phase, each data-register read (address 0) pops one buffer word and returns it. In ECC mode only bits 7..0 are returned, and the upper byte reads as zero.
- R10: In a host-to-device phase, each data-register write pushes one word to the buffer. In ECC mode the pushed word carries write bits 7..0 with the upper byte zero.
- R11: Data-register accesses while DRQ is 0, or against the phase direction, neither pop nor push, and reads return zero.
- R12: On the access that reaches the programmed length, DRQ clears and BSY sets. The end-of-block output then pulses for one cycle.
- R13: An engine release pulse clears BSY when no other event is pending.
- R14: Read data appears on the host data output the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | AW | Host register address |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Registered host read data |
| hst_intrq | output | 1 | Host interrupt line |
| eng_flags | input | 6 | Engine status flags (RDY, DF, DSC, COR, IDX, ERR order, high to low) |
| eng_cmd_start | output | 1 | One-cycle command start |
| eng_cmd_code | output | 8 | Latched command code |
| eng_params | output | NPAR*8 | Parameter bytes frozen at command accept |
| eng_irq_set | input | 1 | Interrupt request pulse |
| eng_xfer_go | input | 1 | Opens a PIO data phase |
| eng_xfer_len | input | CNTW | Word count of the phase |
| eng_xfer_ecc | input | 1 | Byte-wide ECC phase |
| eng_xfer_in | input | 1 | 1 = device to host, 0 = host to device |
| eng_release | input | 1 | Clears BSY |
| eng_blk_end | output | 1 | One-cycle end-of-block pulse |
| buf_rd | output | 1 | Buffer pop |
| buf_rdata | input | DW | Buffer head word |
| buf_wr | output | 1 | Buffer push |
| buf_wdata | output | DW | Buffer push word |

## Verification
The bound checker watches the cycle-local rules on every clock. It checks that BSY and DRQ never overlap, that the buffer is idle without DRQ, and that only status reads drop the pending flag, with a request beating a same-cycle read. It also checks that device-control masking reaches the interrupt line, that accepted and refused command writes give the right start behaviour, and the state at end-of-block. Ordering effects that span many cycles are shown only by the bench scenarios. These include the buffer word order across a phase, the count that ends a phase, ECC lane masking, and the parameter copy staying frozen under later writes.

// File: rtl/tf_pkg.sv
package tf_pkg;
  localparam int TF_ADDR_DATA = 0;
  localparam int TF_ADDR_CMD  = 7;
  localparam int TF_ADDR_CTL  = 14;
  localparam int TF_PAR_BASE  = 1;
  localparam int TF_BYTE      = 8;
  localparam int TF_NIEN_BIT  = 1;
  localparam int TF_FLAGS     = 6;
endpackage

// File: rtl/tf_decode.sv
module tf_decode import tf_pkg::*; #(
  parameter int AW   = 4,
  parameter int NPAR = 6
) (
  input  logic [AW-1:0]   addr,
  input  logic            rd,
  input  logic            wr,
  output logic            rd_data,
  output logic            wr_data,
  output logic            rd_stat,
  output logic            wr_cmd,
  output logic            rd_alt,
  output logic            wr_ctl,
  output logic [NPAR-1:0] rd_par,
  output logic [NPAR-1:0] wr_par
);
  logic hit_data, hit_cmd, hit_ctl;

  assign hit_data = (addr == AW'(TF_ADDR_DATA));
  assign hit_cmd  = (addr == AW'(TF_ADDR_CMD));
  assign hit_ctl  = (addr == AW'(TF_ADDR_CTL));

  assign rd_data = rd && hit_data;
  assign wr_data = wr && hit_data;
  assign rd_stat = rd && hit_cmd;
  assign wr_cmd  = wr && hit_cmd;
  assign rd_alt  = rd && hit_ctl;
  assign wr_ctl  = wr && hit_ctl;

  for (genvar g = 0; g < NPAR; g++) begin : g_par
    assign rd_par[g] = rd && (addr == AW'(TF_PAR_BASE + g));
    assign wr_par[g] = wr && (addr == AW'(TF_PAR_BASE + g));
  end
endmodule

// File: rtl/tf_param_file.sv
module tf_param_file import tf_pkg::*; #(
  parameter int NPAR = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPAR-1:0]         wr_par,
  input  logic [TF_BYTE-1:0]      wbyte,
  input  logic                    snap_en,
  output logic [NPAR*TF_BYTE-1:0] live,
  output logic [NPAR*TF_BYTE-1:0] snap
);
  for (genvar g = 0; g < NPAR; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        live[g*TF_BYTE +: TF_BYTE] <= '0;
      end else if (wr_par[g]) begin
        live[g*TF_BYTE +: TF_BYTE] <= wbyte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (snap_en) begin
      snap <= live;
    end
  end
endmodule

// File: rtl/tf_status_irq.sv
module tf_status_irq (
  input  logic clk,
  input  logic rst,
  input  logic cmd_acc,
  input  logic xfer_go,
  input  logic blk_done,
  input  logic rel_i,
  input  logic irq_set,
  input  logic stat_rd,
  input  logic ctl_wr,
  input  logic nien_bit,
  output logic bsy,
  output logic drq,
  output logic pend,
  output logic intrq
);
  logic bsy_n, drq_n, pend_n, nien_n, nien_q;

  always_comb begin
    bsy_n = bsy;
    drq_n = drq;
    if (xfer_go) begin
      bsy_n = 1'b0;
      drq_n = 1'b1;
    end else if (cmd_acc || blk_done) begin
      bsy_n = 1'b1;
      drq_n = 1'b0;
    end else if (rel_i) begin
      bsy_n = 1'b0;
    end
    if (irq_set)      pend_n = 1'b1;
    else if (stat_rd) pend_n = 1'b0;
    else              pend_n = pend;
    nien_n = ctl_wr ? nien_bit : nien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bsy    <= 1'b0;
      drq    <= 1'b0;
      pend   <= 1'b0;
      nien_q <= 1'b0;
      intrq  <= 1'b0;
    end else begin
      bsy    <= bsy_n;
      drq    <= drq_n;
      pend   <= pend_n;
      nien_q <= nien_n;
      intrq  <= pend_n && !nien_n;
    end
  end
endmodule

// File: rtl/tf_xfer.sv
module tf_xfer #(
  parameter int DW   = 16,
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            xfer_go,
  input  logic [CNTW-1:0] len_in,
  input  logic            ecc_in,
  input  logic            dir_in,
  input  logic            drq,
  input  logic            rd_data,
  input  logic            wr_data,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   buf_rdata,
  output logic            buf_rd,
  output logic            buf_wr,
  output logic [DW-1:0]   buf_wdata,
  output logic [DW-1:0]   rd_word,
  output logic            blk_done
);
  localparam int LANE = DW / 2;

  logic [CNTW-1:0] cnt_q, len_q;
  logic            ecc_q, dir_q, acc;

  assign buf_rd = drq && dir_q && rd_data;
  assign buf_wr = drq && !dir_q && wr_data;
  assign acc    = buf_rd || buf_wr;
  assign blk_done = acc && (CNTW'(cnt_q + 1'b1) == len_q);

  assign buf_wdata = ecc_q ? DW'(wdata[LANE-1:0]) : wdata;

  always_comb begin
    if (!buf_rd)    rd_word = '0;
    else if (ecc_q) rd_word = DW'(buf_rdata[LANE-1:0]);
    else            rd_word = buf_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= '0;
      ecc_q <= 1'b0;
      dir_q <= 1'b0;
    end else if (xfer_go) begin
      cnt_q <= '0;
      len_q <= len_in;
      ecc_q <= ecc_in;
      dir_q <= dir_in;
    end else if (acc) begin
      cnt_q <= CNTW'(cnt_q + 1'b1);
    end
  end
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs import tf_pkg::*; #(
  parameter int AW   = 4,
  parameter int DW   = 16,
  parameter int NPAR = 6,
  parameter int CNTW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AW-1:0]           hst_addr,
  input  logic                    hst_rd,
  input  logic                    hst_wr,
  input  logic [DW-1:0]           hst_wdata,
  output logic [DW-1:0]           hst_rdata,
  output logic                    hst_intrq,
  input  logic [TF_FLAGS-1:0]     eng_flags,
  output logic                    eng_cmd_start,
  output logic [TF_BYTE-1:0]      eng_cmd_code,
  output logic [NPAR*TF_BYTE-1:0] eng_params,
  input  logic                    eng_irq_set,
  input  logic                    eng_xfer_go,
  input  logic [CNTW-1:0]         eng_xfer_len,
  input  logic                    eng_xfer_ecc,
  input  logic                    eng_xfer_in,
  input  logic                    eng_release,
  output logic                    eng_blk_end,
  output logic                    buf_rd,
  input  logic [DW-1:0]           buf_rdata,
  output logic                    buf_wr,
  output logic [DW-1:0]           buf_wdata
);
  localparam int PW = NPAR * TF_BYTE;

  logic            rd_data, wr_data, rd_stat, wr_cmd, rd_alt, wr_ctl;
  logic [NPAR-1:0] rd_par, wr_par;
  logic            bsy, drq, pend, cmd_acc, blk_done;
  logic [PW-1:0]   par_live;
  logic [DW-1:0]   rd_word, rd_next;
  logic [TF_BYTE-1:0] status_byte;

  tf_decode #(.AW(AW), .NPAR(NPAR)) u_dec (
    .addr(hst_addr), .rd(hst_rd), .wr(hst_wr),
    .rd_data(rd_data), .wr_data(wr_data), .rd_stat(rd_stat),
    .wr_cmd(wr_cmd), .rd_alt(rd_alt), .wr_ctl(wr_ctl),
    .rd_par(rd_par), .wr_par(wr_par)
  );

  assign cmd_acc = wr_cmd && !bsy;

  tf_status_irq u_stat (
    .clk(clk), .rst(rst), .cmd_acc(cmd_acc), .xfer_go(eng_xfer_go),
    .blk_done(blk_done), .rel_i(eng_release), .irq_set(eng_irq_set),
    .stat_rd(rd_stat), .ctl_wr(wr_ctl), .nien_bit(hst_wdata[TF_NIEN_BIT]),
    .bsy(bsy), .drq(drq), .pend(pend), .intrq(hst_intrq)
  );

  tf_param_file #(.NPAR(NPAR)) u_par (
    .clk(clk), .rst(rst), .wr_par(wr_par), .wbyte(hst_wdata[TF_BYTE-1:0]),
    .snap_en(cmd_acc), .live(par_live), .snap(eng_params)
  );

  tf_xfer #(.DW(DW), .CNTW(CNTW)) u_xfer (
    .clk(clk), .rst(rst), .xfer_go(eng_xfer_go), .len_in(eng_xfer_len),
    .ecc_in(eng_xfer_ecc), .dir_in(eng_xfer_in), .drq(drq),
    .rd_data(rd_data), .wr_data(wr_data), .wdata(hst_wdata),
    .buf_rdata(buf_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .rd_word(rd_word), .blk_done(blk_done)
  );

  assign status_byte = {bsy, eng_flags[5:3], drq, eng_flags[2:0]};

  always_comb begin
    rd_next = '0;
    if (rd_stat || rd_alt) rd_next = DW'(status_byte);
    if (rd_data)           rd_next = rd_word;
    for (int i = 0; i < NPAR; i++) begin
      if (rd_par[i]) rd_next = DW'(par_live[i*TF_BYTE +: TF_BYTE]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata     <= '0;
      eng_cmd_start <= 1'b0;
      eng_cmd_code  <= '0;
      eng_blk_end   <= 1'b0;
    end else begin
      eng_cmd_start <= cmd_acc;
      eng_blk_end   <= blk_done;
      if (cmd_acc) eng_cmd_code <= hst_wdata[TF_BYTE-1:0];
      if (hst_rd)  hst_rdata    <= rd_next;
    end
  end
endmodule

// File: rtl/ata_taskfile_regs_chk.sv
module ata_taskfile_regs_chk import tf_pkg::*; #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] hst_addr,
  input logic          hst_rd,
  input logic          hst_wr,
  input logic [DW-1:0] hst_wdata,
  input logic          hst_intrq,
  input logic          eng_cmd_start,
  input logic [7:0]    eng_cmd_code,
  input logic          eng_irq_set,
  input logic          eng_xfer_go,
  input logic          eng_blk_end,
  input logic          buf_rd,
  input logic          buf_wr,
  input logic          bsy,
  input logic          drq,
  input logic          pend
);
  logic a_cmd, a_ctl;
  assign a_cmd = (hst_addr == AW'(TF_ADDR_CMD));
  assign a_ctl = (hst_addr == AW'(TF_ADDR_CTL));

  p_alt_keeps_pend_r2: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && a_ctl && !eng_irq_set) |=> (pend == $past(pend)));

  p_stat_ack_r3: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && a_cmd && !eng_irq_set) |=> !pend);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    eng_irq_set |=> pend);

  p_mask_line_r4: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && a_ctl && hst_wdata[TF_NIEN_BIT]) |=> !hst_intrq);

  p_cmd_start_r5: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && a_cmd && !bsy && !eng_xfer_go) |=>
      (eng_cmd_start && eng_cmd_code == $past(hst_wdata[7:0]) && bsy));

  p_cmd_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (hst_wr && a_cmd && bsy) |=> !eng_cmd_start);

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(bsy && drq));

  p_idle_port_r11: assert property (@(posedge clk) disable iff (rst)
    !drq |-> (!buf_rd && !buf_wr));

  p_end_state_r12: assert property (@(posedge clk) disable iff (rst)
    eng_blk_end |-> (bsy && !drq));
endmodule

bind ata_taskfile_regs ata_taskfile_regs_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_rd(hst_rd),
  .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_intrq(hst_intrq),
  .eng_cmd_start(eng_cmd_start), .eng_cmd_code(eng_cmd_code),
  .eng_irq_set(eng_irq_set), .eng_xfer_go(eng_xfer_go),
  .eng_blk_end(eng_blk_end), .buf_rd(buf_rd), .buf_wr(buf_wr),
  .bsy(bsy), .drq(drq), .pend(pend)
);

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  hst_addr = '0;
  logic        hst_rd = 1'b0, hst_wr = 1'b0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        hst_intrq;
  logic [5:0]  eng_flags = '0;
  logic        eng_cmd_start;
  logic [7:0]  eng_cmd_code;
  logic [47:0] eng_params;
  logic        eng_irq_set = 1'b0, eng_xfer_go = 1'b0;
  logic [15:0] eng_xfer_len = '0;
  logic        eng_xfer_ecc = 1'b0, eng_xfer_in = 1'b0, eng_release = 1'b0;
  logic        eng_blk_end, buf_rd, buf_wr;
  logic [15:0] buf_rdata, buf_wdata;

  logic [15:0] src_mem [0:63];
  int          src_idx = 0;
  assign buf_rdata = src_mem[src_idx[5:0]];

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile_regs u_dut (
    .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_rd(hst_rd), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_intrq(hst_intrq),
    .eng_flags(eng_flags), .eng_cmd_start(eng_cmd_start), .eng_cmd_code(eng_cmd_code),
    .eng_params(eng_params), .eng_irq_set(eng_irq_set), .eng_xfer_go(eng_xfer_go),
    .eng_xfer_len(eng_xfer_len), .eng_xfer_ecc(eng_xfer_ecc), .eng_xfer_in(eng_xfer_in),
    .eng_release(eng_release), .eng_blk_end(eng_blk_end), .buf_rd(buf_rd),
    .buf_rdata(buf_rdata), .buf_wr(buf_wr), .buf_wdata(buf_wdata)
  );

  // behavioural reference
  int m_bsy, m_drq, m_pend, m_nien, m_intr, m_cnt, m_len, m_ecc, m_dir;
  int m_rdata, m_start, m_code, m_end;
  int m_par [6];
  int m_snap [6];

  function automatic int m_status();
    return (m_bsy << 7) | (int'(eng_flags[5:3]) << 4) | (m_drq << 3) | int'(eng_flags[2:0]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_bsy = 0; m_drq = 0; m_pend = 0; m_nien = 0; m_intr = 0; m_cnt = 0;
      m_len = 0; m_ecc = 0; m_dir = 0; m_rdata = 0; m_start = 0; m_code = 0; m_end = 0;
      foreach (m_par[i]) begin m_par[i] = 0; m_snap[i] = 0; end
    end else begin
      int a;
      bit acc, cmd_acc, done;
      a = int'(hst_addr);
      cmd_acc = hst_wr && a == 7 && m_bsy == 0;
      acc = m_drq == 1 && a == 0 && ((hst_rd && m_dir == 1) || (hst_wr && m_dir == 0));
      done = acc && (m_cnt + 1) == m_len;
      if (hst_rd) begin
        if (a == 7 || a == 14) m_rdata = m_status();
        else if (a == 0) m_rdata = acc ? (m_ecc == 1 ? int'(buf_rdata[7:0]) : int'(buf_rdata)) : 0;
        else if (a >= 1 && a <= 6) m_rdata = m_par[a-1];
        else m_rdata = 0;
      end
      if (acc) begin
        m_cnt++;
        if (m_dir == 1) src_idx <= src_idx + 1;
      end
      m_start = cmd_acc;
      m_end = done;
      if (cmd_acc) begin
        m_code = int'(hst_wdata[7:0]);
        foreach (m_par[i]) m_snap[i] = m_par[i];
      end
      if (hst_wr && a >= 1 && a <= 6) m_par[a-1] = int'(hst_wdata[7:0]);
      if (hst_wr && a == 14) m_nien = int'(hst_wdata[1]);
      if (eng_irq_set) m_pend = 1;
      else if (hst_rd && a == 7) m_pend = 0;
      if (eng_xfer_go) begin
        m_drq = 1; m_bsy = 0; m_cnt = 0; m_len = int'(eng_xfer_len);
        m_ecc = int'(eng_xfer_ecc); m_dir = int'(eng_xfer_in);
      end else if (cmd_acc || done) begin
        m_bsy = 1; m_drq = 0;
      end else if (eng_release) begin
        m_bsy = 0;
      end
      m_intr = (m_pend == 1 && m_nien == 0) ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic comb_check();
    bit ebr, ebw;
    int ew;
    ebr = m_drq == 1 && m_dir == 1 && hst_rd && hst_addr == 0;
    ebw = m_drq == 1 && m_dir == 0 && hst_wr && hst_addr == 0;
    ew = (m_ecc == 1) ? int'(hst_wdata[7:0]) : int'(hst_wdata);
    chk(buf_rd == ebr, "buf_rd", int'(buf_rd), int'(ebr));
    chk(buf_wr == ebw, "buf_wr", int'(buf_wr), int'(ebw));
    if (ebw) chk(int'(buf_wdata) == ew, "buf_wdata", int'(buf_wdata), ew);
  endtask

  task automatic reg_check();
    int es;
    es = (m_snap[5] << 40) | 0;
    chk(int'(hst_rdata) == m_rdata, "hst_rdata", int'(hst_rdata), m_rdata);
    chk(int'(hst_intrq) == m_intr, "hst_intrq", int'(hst_intrq), m_intr);
    chk(int'(eng_cmd_start) == m_start, "eng_cmd_start", int'(eng_cmd_start), m_start);
    chk(int'(eng_cmd_code) == m_code, "eng_cmd_code", int'(eng_cmd_code), m_code);
    chk(int'(eng_blk_end) == m_end, "eng_blk_end", int'(eng_blk_end), m_end);
    for (int i = 0; i < 6; i++)
      chk(int'(eng_params[i*8 +: 8]) == m_snap[i], "eng_params", int'(eng_params[i*8 +: 8]), m_snap[i]);
    if (es < 0) chk(1'b0, "unreachable", es, 0);
  endtask

  task automatic tick();
    #1 comb_check();
    @(negedge clk);
    reg_check();
  endtask

  task automatic wr(input int a, input int d);
    hst_addr = 4'(a); hst_wdata = 16'(d); hst_wr = 1'b1;
    tick();
    hst_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    hst_addr = 4'(a); hst_rd = 1'b1;
    tick();
    hst_rd = 1'b0;
    v = int'(hst_rdata);
  endtask

  task automatic go(input int len, input bit ecc, input bit dir_in);
    eng_xfer_go = 1'b1; eng_xfer_len = 16'(len); eng_xfer_ecc = ecc; eng_xfer_in = dir_in;
    tick();
    eng_xfer_go = 1'b0;
  endtask

  task automatic pulse_irq();
    eng_irq_set = 1'b1; tick(); eng_irq_set = 1'b0;
  endtask

  task automatic release_bsy();
    eng_release = 1'b1; tick(); eng_release = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, idx0;
    for (int i = 0; i < 64; i++) src_mem[i] = 16'(16'hA100 + i * 16'h0111);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();

    cur_req = "R1";
    rd(7, v); chk(v == 0, "reset status R1", v, 0);
    eng_flags = 6'h3F;
    rd(7, v); chk(v == 'h77, "status layout R1", v, 'h77);

    cur_req = "R7";
    for (int i = 1; i <= 6; i++) wr(i, 'h5500 + i * 'h11);
    rd(3, v); chk(v == 'h33, "param readback R7", v, 'h33);

    cur_req = "R5";
    wr(7, 'h1220);
    chk(eng_cmd_start == 1'b1, "start pulse R5", int'(eng_cmd_start), 1);
    chk(eng_cmd_code == 8'h20, "code R5", int'(eng_cmd_code), 'h20);
    chk(eng_params[15:8] == 8'h22, "snapshot R7", int'(eng_params[15:8]), 'h22);
    tick();
    chk(eng_cmd_start == 1'b0, "single pulse R5", int'(eng_cmd_start), 0);
    rd(14, v); chk(v == 'hF7, "busy in alt status R5", v, 'hF7);

    cur_req = "R6";
    wr(7, 'h30);
    chk(eng_cmd_start == 1'b0, "busy command ignored R6", int'(eng_cmd_start), 0);
    chk(eng_cmd_code == 8'h20, "code kept R6", int'(eng_cmd_code), 'h20);
    cur_req = "R7";
    wr(2, 'h9A); tick();
    chk(eng_params[15:8] == 8'h22, "snapshot frozen R7", int'(eng_params[15:8]), 'h22);

    cur_req = "R13";
    release_bsy();
    rd(7, v); chk(v == 'h77, "release clears BSY R13", v, 'h77);

    cur_req = "R4";
    pulse_irq(); tick();
    chk(hst_intrq == 1'b1, "line raised R4", int'(hst_intrq), 1);
    cur_req = "R2";
    rd(14, v); tick();
    chk(hst_intrq == 1'b1, "alt read keeps pending R2", int'(hst_intrq), 1);
    cur_req = "R3";
    rd(7, v); tick();
    chk(hst_intrq == 1'b0, "status read acks R3", int'(hst_intrq), 0);
    eng_irq_set = 1'b1; rd(7, v); eng_irq_set = 1'b0; tick();
    chk(hst_intrq == 1'b1, "set wins over ack R3", int'(hst_intrq), 1);
    cur_req = "R4";
    wr(14, 'h02);
    chk(hst_intrq == 1'b0, "disable masks R4", int'(hst_intrq), 0);
    wr(14, 'h00);
    chk(hst_intrq == 1'b1, "enable restores R4", int'(hst_intrq), 1);
    rd(7, v);

    cur_req = "R11";
    idx0 = src_idx;
    rd(0, v); chk(v == 0, "read without DRQ R11", v, 0);
    wr(0, 'h1234);
    chk(src_idx == idx0, "no pop without DRQ R11", src_idx, idx0);

    cur_req = "R8";
    wr(7, 'hC4); go(4, 1'b0, 1'b1);
    rd(7, v); chk(v == 'h7F, "DRQ open R8", v, 'h7F);
    cur_req = "R9";
    for (int k = 0; k < 3; k++) begin
      rd(0, v); chk(v == int'(src_mem[idx0 + k]), "word order R9", v, int'(src_mem[idx0 + k]));
    end
    cur_req = "R11";
    wr(0, 'hBEEF);
    cur_req = "R12";
    rd(0, v); chk(v == int'(src_mem[idx0 + 3]), "last word R12", v, int'(src_mem[idx0 + 3]));
    chk(eng_blk_end == 1'b1, "end pulse R12", int'(eng_blk_end), 1);
    tick();
    chk(eng_blk_end == 1'b0, "end pulse single R12", int'(eng_blk_end), 0);
    rd(7, v); chk(v == 'hF7, "BSY after block R12", v, 'hF7);

    cur_req = "R9";
    go(2, 1'b1, 1'b1);
    rd(0, v); chk(v == int'(src_mem[idx0 + 4][7:0]), "ecc low lane R9", v, int'(src_mem[idx0 + 4][7:0]));
    rd(0, v);
    release_bsy();

    cur_req = "R10";
    go(3, 1'b0, 1'b0);
    cur_req = "R11";
    idx0 = src_idx;
    rd(0, v); chk(src_idx == idx0 && v == 0, "wrong direction read R11", v, 0);
    cur_req = "R10";
    wr(0, 'hCAFE); wr(0, 'h0102); wr(0, 'h7788);
    go(1, 1'b1, 1'b0);
    wr(0, 'hABCD);
    cur_req = "R14";
    tick(); tick();
    chk(hst_rdata == 16'h0, "read data holds R14", int'(hst_rdata), 0);
    release_bsy();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule